// File: doc/BRIEF.md
# SATA Host Adapter Global Register Region

This block holds the adapter-wide register region of a SATA host controller. The bus is 32 bits wide and addressed by dword index. The first 256 bytes are the global region. Above it, each port gets a window of 0x80 bytes. Port n's window starts at byte 0x100 + n*0x80, so a 4 KiB space holds at most 30 port windows.

The global region returns these values:
- the capabilities word;
- the host control word, which carries adapter-enable, interrupt-enable and host-reset;
- a per-port interrupt status word;
- the implemented-ports map;
- a fixed version word.

Every other dword of the global region reads as zero.

An access that falls in the window of an implemented port is passed to that port through a one-hot select. The port's read data is returned on the bus. Windows of ports that are not implemented, or that lie beyond the port count, read as zero. The block also collects each port's interrupt line into a sticky status bit and drives one host interrupt from them.

Top module: `hba_global_regs`

## Requirements
- R1: Byte address 0x100 + n*0x80 + 4*k, with n an implemented port, asserts `port_req` and `port_sel[n]` alone, with `port_offs` = k. A read returns that port's `port_rdata` slice.
- R2: The capabilities word (byte 0x000) has these fields:
  - bits [4:0] hold the port count minus one;
  - bits [12:8] hold the command-slot count minus one;
  - bit 18 holds the adapter-only parameter;
  - all other bits are 0.
- R3: The implemented-ports word (byte 0x00C) returns the implemented-port bitmap, with bit n standing for port n.
- R4: The version word (byte 0x010) reads 0x00010300.
- R5: The host control word (byte 0x004) has host-reset at bit 0, interrupt-enable at bit 1, single-message at bit 2 and adapter-enable at bit 31. After reset it reads 0. With the adapter-only parameter set, bit 31 reads 1 and writes do not change it.
- R6: With the adapter-only parameter clear, bits 31 and 1 of the host control word are writable and read back as written.
- R7: An interrupt status bit (byte 0x008, bit n for port n) sets on a rising edge of `port_irq[n]` and stays set after the line falls. Only the edge counts, not the level. Lines of unimplemented ports never set a bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A rising edge in the same cycle as the clear leaves the bit set.
- R9: `host_irq` is 1 exactly when interrupt-enable is 1 and at least one status bit is set.
- R10: Writing 1 to bit 0 of the host control word has these effects:
  - status bits, interrupt-enable and a writable adapter-enable are cleared;
  - `port_reset` is 1 for exactly the next cycle;
  - rising edges during that cycle are ignored;
  - bit 0 then reads 0.
- R11: Global dwords 5 to 63 (bytes 0x014 to 0x0FC) read 0. Writes to them and to the capabilities, implemented-ports and version words are ignored.
- R12: A port window that is unimplemented, or beyond the port count, reads 0 and does not assert `port_req`.
- R13: A read presented in one cycle returns `rdata` with `rvalid` = 1 after the next clock edge. `rvalid` is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| dw_addr | input | ADDR_W-2 | Dword address |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| port_req | output | 1 | Access to an implemented port window |
| port_sel | output | NUM_PORTS | One-hot port select |
| port_we | output | 1 | Write strobe to ports |
| port_offs | output | 5 | Dword offset inside the port window |
| port_wdata | output | 32 | Write data to ports |
| port_rdata | input | NUM_PORTS*32 | Read data from ports, port n in slice n |
| port_irq | input | NUM_PORTS | Per-port interrupt lines |
| port_reset | output | 1 | One-cycle reset pulse to all ports |
| host_irq | output | 1 | Aggregated host interrupt |

## Verification
The decoder is exercised with a table of read addresses:
- every named global word;
- scattered reserved dwords;
- first, middle and last offsets of implemented port windows;
- windows of unimplemented ports, windows beyond the port count, and the topmost window.

Together these separate a wrong window base, a wrong port index and a missing implemented-port check. The interrupt path is driven with:
- a single rising edge followed by the line falling;
- a held line;
- an edge on an unimplemented port;
- a clear that coincides with an edge.

These cases separate edge capture from level capture and decide set-versus-clear priority. A second instance with the adapter-only parameter set shows that adapter-enable is fixed, including across a host reset.

// File: rtl/hba_global_regs.sv
module hba_global_regs #(
  parameter int NUM_PORTS = 6,
  parameter logic [NUM_PORTS-1:0] PORT_MAP = 6'b110101,
  parameter int NUM_SLOTS = 32,
  parameter bit AHCI_ONLY = 1'b0,
  parameter int ADDR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ADDR_W-3:0]      dw_addr,
  input  logic [31:0]            wdata,
  output logic                   rvalid,
  output logic [31:0]            rdata,
  output logic                   port_req,
  output logic [NUM_PORTS-1:0]   port_sel,
  output logic                   port_we,
  output logic [4:0]             port_offs,
  output logic [31:0]            port_wdata,
  input  logic [NUM_PORTS*32-1:0] port_rdata,
  input  logic [NUM_PORTS-1:0]   port_irq,
  output logic                   port_reset,
  output logic                   host_irq
);
  localparam int DW = ADDR_W - 2;
  localparam int PW = DW - 5;
  localparam logic [31:0] CAP_VAL = (32'(AHCI_ONLY) << 18) |
                                    (32'(NUM_SLOTS - 1) << 8) |
                                    32'(NUM_PORTS - 1);
  localparam logic [31:0] VS_VAL = 32'h0001_0300;
  localparam logic [5:0] IDX_CAP = 6'd0;
  localparam logic [5:0] IDX_GHC = 6'd1;
  localparam logic [5:0] IDX_IS  = 6'd2;
  localparam logic [5:0] IDX_PI  = 6'd3;
  localparam logic [5:0] IDX_VS  = 6'd4;

  logic                 ie_q, ae_q, hr_q;
  logic [NUM_PORTS-1:0] is_q, irq_prev, rise;
  logic [31:0]          rd_mux, glob_rd, port_rd;
  logic                 in_glob, rd_req, wr_ghc, wr_is, hr_wr, ae_rd;
  logic [PW-1:0]        pidx;

  assign in_glob = (dw_addr[DW-1:6] == '0);
  assign pidx    = dw_addr[DW-1:5] - PW'(2);
  assign rd_req  = req && !we;
  assign wr_ghc  = req && we && in_glob && (dw_addr[5:0] == IDX_GHC);
  assign wr_is   = req && we && in_glob && (dw_addr[5:0] == IDX_IS);
  assign hr_wr   = wr_ghc && wdata[0];
  assign ae_rd   = AHCI_ONLY ? 1'b1 : ae_q;
  assign rise    = port_irq & ~irq_prev & PORT_MAP;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++)
      port_sel[i] = req && !in_glob && (pidx == PW'(i)) && PORT_MAP[i];
  end

  assign port_req   = |port_sel;
  assign port_we    = we;
  assign port_offs  = dw_addr[4:0];
  assign port_wdata = wdata;
  assign port_reset = hr_q;
  assign host_irq   = ie_q && (|is_q);

  always_comb begin
    case (dw_addr[5:0])
      IDX_CAP: glob_rd = CAP_VAL;
      IDX_GHC: glob_rd = {ae_rd, 28'd0, 1'b0, ie_q, hr_q};
      IDX_IS:  glob_rd = 32'(is_q);
      IDX_PI:  glob_rd = 32'(PORT_MAP);
      IDX_VS:  glob_rd = VS_VAL;
      default: glob_rd = '0;
    endcase
  end

  always_comb begin
    port_rd = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (port_sel[i]) port_rd = port_rd | port_rdata[i*32 +: 32];
  end

  assign rd_mux = in_glob ? glob_rd : port_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      ae_q     <= 1'b0;
      hr_q     <= 1'b0;
      is_q     <= '0;
      irq_prev <= '0;
    end else begin
      irq_prev <= port_irq;
      if (hr_wr) begin
        hr_q <= 1'b1;
        ie_q <= 1'b0;
        ae_q <= 1'b0;
        is_q <= '0;
      end else begin
        hr_q <= 1'b0;
        if (wr_ghc) begin
          ie_q <= wdata[1];
          if (!AHCI_ONLY) ae_q <= wdata[31];
        end
        if (hr_q) is_q <= '0;
        else is_q <= (is_q & ~(wr_is ? wdata[NUM_PORTS-1:0] : '0)) | rise;
      end
    end
  end

  // R10
  hr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_q |=> !hr_q);

  // R10
  hr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_wr |=> (is_q == '0 && !ie_q && port_reset));

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_sel));

  // R7
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rise) && !hr_q && !hr_wr) |=> ((is_q & $past(rise)) == $past(rise)));

  // R13
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);

  // R12
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !in_glob && !port_req) |=> (rdata == 32'd0));
endmodule

// File: tb/tb_hba_global_regs.sv
`timescale 1ns/1ps
module tb_hba_global_regs;
  localparam int NP = 6;
  localparam int NV = 16;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req = 0, we = 0;
  logic [9:0] dw_addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid, port_req, port_we, port_reset, host_irq;
  logic [31:0] rdata, port_wdata;
  logic [NP-1:0] port_sel;
  logic [NP-1:0] port_irq = '0;
  logic [4:0] port_offs;
  logic [NP*32-1:0] port_rdata;

  logic ao_req = 0, ao_we = 0;
  logic [9:0] ao_addr = '0;
  logic [31:0] ao_wdata = '0;
  logic ao_rvalid, ao_preq, ao_pwe, ao_preset, ao_hirq;
  logic [31:0] ao_rdata, ao_pwdata;
  logic [NP-1:0] ao_psel;
  logic [4:0] ao_poffs;

  int checks = 0, errors = 0;
  bit done = 0;

  always_comb begin
    for (int n = 0; n < NP; n++)
      port_rdata[n*32 +: 32] = 32'h5100_0000 | (32'(n) << 8) | 32'(port_offs);
  end

  hba_global_regs dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .dw_addr(dw_addr), .wdata(wdata),
    .rvalid(rvalid), .rdata(rdata), .port_req(port_req), .port_sel(port_sel),
    .port_we(port_we), .port_offs(port_offs), .port_wdata(port_wdata),
    .port_rdata(port_rdata), .port_irq(port_irq), .port_reset(port_reset),
    .host_irq(host_irq));

  hba_global_regs #(.AHCI_ONLY(1'b1)) dut_ao (
    .clk(clk), .rst_n(rst_n), .req(ao_req), .we(ao_we), .dw_addr(ao_addr), .wdata(ao_wdata),
    .rvalid(ao_rvalid), .rdata(ao_rdata), .port_req(ao_preq), .port_sel(ao_psel),
    .port_we(ao_pwe), .port_offs(ao_poffs), .port_wdata(ao_pwdata),
    .port_rdata('0), .port_irq('0), .port_reset(ao_preset), .host_irq(ao_hirq));

  // {tag, byte address, expected}: R2 caps, R3 map, R4 version,
  // R11 reserved dwords, R1 implemented windows, R12 empty windows
  localparam logic [51:0] VEC [NV] = '{
    {8'd2,  12'h000, 32'h0000_1F05},
    {8'd3,  12'h00C, 32'h0000_0035},
    {8'd4,  12'h010, 32'h0001_0300},
    {8'd11, 12'h014, 32'h0},
    {8'd11, 12'h028, 32'h0},
    {8'd11, 12'h030, 32'h0},
    {8'd11, 12'h0A0, 32'h0},
    {8'd11, 12'h0FC, 32'h0},
    {8'd1,  12'h100, 32'h5100_0000},
    {8'd1,  12'h20C, 32'h5100_0203},
    {8'd1,  12'h304, 32'h5100_0401},
    {8'd1,  12'h3FC, 32'h5100_051F},
    {8'd12, 12'h180, 32'h0},
    {8'd12, 12'h284, 32'h0},
    {8'd12, 12'h400, 32'h0},
    {8'd12, 12'hF80, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; dw_addr = a[11:2]; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; dw_addr = a[11:2];
    @(negedge clk);
    req = 0;
    d = rdata;
    chk("R13 rvalid", 32'(rvalid), 32'd1);
  endtask

  task automatic ao_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ao_req = 1; ao_we = 1; ao_addr = a[11:2]; ao_wdata = d;
    @(negedge clk);
    ao_req = 0; ao_we = 0;
  endtask

  task automatic ao_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    ao_req = 1; ao_we = 0; ao_addr = a[11:2];
    @(negedge clk);
    ao_req = 0;
    d = ao_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset state
    chk("R13 rvalid idle", 32'(rvalid), 32'd0);
    chk("R9 host_irq reset", 32'(host_irq), 32'd0);
    chk("R10 port_reset idle", 32'(port_reset), 32'd0);
    do_read(12'h004, d); chk("R5 ghc reset", d, 32'h0);
    do_read(12'h008, d); chk("R7 is reset", d, 32'h0);
    @(negedge clk);
    chk("R13 rvalid drops", 32'(rvalid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][43:32], d);
      chk($sformatf("R%0d addr %h", VEC[i][51:44], VEC[i][43:32]), d, VEC[i][31:0]);
    end

    // R1 forwarding strobes during the request cycle
    @(negedge clk);
    req = 1; we = 1; dw_addr = 10'h083; wdata = 32'hA5A5_0001;
    #1;
    chk("R1 port_sel", 32'(port_sel), 32'h4);
    chk("R1 port_req", 32'(port_req), 32'd1);
    chk("R1 port_offs", 32'(port_offs), 32'd3);
    chk("R1 port_we", 32'(port_we), 32'd1);
    chk("R1 port_wdata", port_wdata, 32'hA5A5_0001);
    dw_addr = 10'h060;
    #1;
    chk("R12 no port_req", 32'(port_req), 32'd0);
    @(negedge clk);
    req = 0; we = 0;

    // R11 writes to fixed and reserved words ignored
    do_write(12'h014, 32'hFFFF_FFFF);
    do_write(12'h000, 32'hFFFF_FFFF);
    do_write(12'h010, 32'h0);
    do_read(12'h014, d); chk("R11 reserved write", d, 32'h0);
    do_read(12'h000, d); chk("R11 caps write", d, 32'h0000_1F05);
    do_read(12'h010, d); chk("R11 version write", d, 32'h0001_0300);

    // R6 writable enables
    do_write(12'h004, 32'h8000_0002);
    do_read(12'h004, d); chk("R6 ghc rw", d, 32'h8000_0002);
    chk("R9 ie with no status", 32'(host_irq), 32'd0);
    do_write(12'h004, 32'h0);
    do_read(12'h004, d); chk("R6 ghc cleared", d, 32'h0);

    // R7 edge capture, sticky
    @(negedge clk); port_irq[2] = 1;
    @(negedge clk); port_irq[2] = 0;
    do_read(12'h008, d); chk("R7 sticky bit", d, 32'h04);
    chk("R9 ie off", 32'(host_irq), 32'd0);
    @(negedge clk); port_irq[1] = 1;
    @(negedge clk); port_irq[1] = 0;
    do_read(12'h008, d); chk("R7 unimplemented line", d, 32'h04);
    do_write(12'h004, 32'h2);
    chk("R9 host_irq on", 32'(host_irq), 32'd1);

    // R8 write-one-to-clear
    do_write(12'h008, 32'h0);
    do_read(12'h008, d); chk("R8 write zero keeps", d, 32'h04);
    do_write(12'h008, 32'h04);
    do_read(12'h008, d); chk("R8 cleared", d, 32'h0);
    chk("R9 host_irq off", 32'(host_irq), 32'd0);
    @(negedge clk);
    req = 1; we = 1; dw_addr = 10'h002; wdata = 32'h01; port_irq[0] = 1;
    @(negedge clk);
    req = 0; we = 0;
    do_read(12'h008, d); chk("R8 edge beats clear", d, 32'h01);
    do_write(12'h008, 32'h01);
    do_read(12'h008, d); chk("R7 level not recaptured", d, 32'h0);
    @(negedge clk); port_irq[0] = 0;

    // R10 host reset
    do_write(12'h004, 32'h8000_0002);
    @(negedge clk); port_irq[4] = 1;
    @(negedge clk);
    chk("R9 host_irq set", 32'(host_irq), 32'd1);
    do_write(12'h004, 32'h1);
    chk("R10 port_reset pulse", 32'(port_reset), 32'd1);
    @(negedge clk);
    chk("R10 port_reset ends", 32'(port_reset), 32'd0);
    do_read(12'h004, d); chk("R10 ghc after reset", d, 32'h0);
    do_read(12'h008, d); chk("R10 status after reset", d, 32'h0);
    chk("R10 host_irq after reset", 32'(host_irq), 32'd0);
    port_irq[4] = 0;

    // R5 adapter-only instance
    ao_read(12'h004, d); chk("R5 ao enable fixed", d, 32'h8000_0000);
    ao_read(12'h000, d); chk("R2 ao caps", d, 32'h0004_1F05);
    ao_write(12'h004, 32'h0);
    ao_read(12'h004, d); chk("R5 ao write ignored", d, 32'h8000_0000);
    ao_write(12'h004, 32'h1);
    @(negedge clk);
    ao_read(12'h004, d); chk("R5 ao survives reset", d, 32'h8000_0000);

    done = 1;
    finish_run();
  end
endmodule